// File: doc/BRIEF.md
# Clustered ALU with Idle-Timeout Power Gating

This block is an integer ALU divided into several sub-units. Each sub-unit owns a fixed group of opcodes, and the block selects the owning sub-unit's output as its single result. A sub-unit draws power only while it is in use or recently used. A per-unit controller counts idle cycles and drops the unit's power enable once the count reaches a threshold that is given at run time. Logic that sits on the analog switches uses one enable output per sub-unit.

An operation is offered with a valid flag, a 4-bit opcode and two operands. If the owning sub-unit is powered and settled, the operation is accepted in the same cycle and its result appears, registered, on the next cycle. If the owning unit is gated, the block raises that unit's enable and holds `in_ready` low for a fixed wake-up time. After that the same operation is accepted. The number of sub-units is a build parameter, with 3-unit and 4-unit groupings.

Top module: `alu_pg_top`

## Requirements
- R1: Opcodes map to sub-units as follows. With NUM_UNITS=4: unit 0 takes ADD(0), SUB(1) and the unused codes 12..15; unit 1 takes AND(2), OR(3), XOR(4) and PASS(10); unit 2 takes SLL(5), SRL(6) and SRA(7); unit 3 takes SLT(8), SLTU(9) and CMPEQ(11). Only a unit that has received an operation since reset, and has not timed out since, has its `pwr_en` bit high.
- R2: Results are: a+b; a-b; a&b; a|b; a^b; a shifted left or right (logical) by b[4:0]; a arithmetically shifted right by b[4:0]; 1 if a<b signed, else 0; 1 if a<b unsigned, else 0; a; 1 if a==b, else 0. Codes 12..15 give 0.
- R3: `out_valid` is high in exactly the cycle after an accepted operation (`in_valid` and `in_ready` both high), and it is low at all other times. `out_result` carries that operation's result.
- R4: During and right after reset, every `pwr_en` bit and `out_valid` are low.
- R5: An operation whose unit is gated sees `in_ready` low for WAKE_CYCLES cycles (default 2), starting with the cycle it is first offered. The unit's `pwr_en` rises in the next cycle. An operation whose unit is powered and settled is accepted with no stall.
- R6: With `idle_limit`=L, a unit that accepted an operation in cycle t and receives nothing more keeps `pwr_en` high through cycle t+L and low from t+L+1. This holds for L = 10, 20, 50, 100 and 500.
- R7: An operation accepted in a unit's last powered cycle (t+L) is accepted without stall, and the timeout restarts from that acceptance.
- R8: Each unit's timeout depends only on its own operations. Traffic to another unit does not shift it.
- R9: With NUM_UNITS=3, SLT, SLTU and CMPEQ belong to unit 0 together with ADD and SUB, and there is no unit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_op | input | 4 | Opcode |
| in_a | input | DATA_W | First operand |
| in_b | input | DATA_W | Second operand / shift amount |
| idle_limit | input | CNT_W | Idle cycles before a unit is gated |
| in_ready | output | 1 | Owning unit can accept this cycle |
| out_valid | output | 1 | Result valid |
| out_result | output | DATA_W | Registered result |
| pwr_en | output | NUM_UNITS | Per-unit power enable |

## Verification
The hardest case to reach from the ports is an operation that arrives in the very last powered cycle of a unit's idle window. One cycle earlier shows nothing, and one cycle later turns the case into a wake-up stall. The stimulus counts falling clock edges from the accepting edge and offers the next operation in cycle t+L exactly. It then checks for a zero-stall acceptance and for a fresh window of L cycles. A second sequence interleaves operations to two units so that their windows overlap, which shows that each window expires on its own schedule.

// File: rtl/alu_pg_pkg.sv
package alu_pg_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_ADD   = 4'd0,
        OP_SUB   = 4'd1,
        OP_AND   = 4'd2,
        OP_OR    = 4'd3,
        OP_XOR   = 4'd4,
        OP_SLL   = 4'd5,
        OP_SRL   = 4'd6,
        OP_SRA   = 4'd7,
        OP_SLT   = 4'd8,
        OP_SLTU  = 4'd9,
        OP_PASS  = 4'd10,
        OP_CMPEQ = 4'd11
    } alu_op_e;

    typedef enum logic [1:0] {
        CL_ARITH = 2'd0,
        CL_LOGIC = 2'd1,
        CL_SHIFT = 2'd2,
        CL_CMP   = 2'd3
    } cluster_e;

    // Static grouping; with fewer than four units the compare group folds into arith.
    function automatic cluster_e unit_of(logic [OPC_W-1:0] op, int unsigned n_units);
        cluster_e c;
        case (op)
            OP_AND, OP_OR, OP_XOR, OP_PASS: c = CL_LOGIC;
            OP_SLL, OP_SRL, OP_SRA:         c = CL_SHIFT;
            OP_SLT, OP_SLTU, OP_CMPEQ:      c = (n_units > 3) ? CL_CMP : CL_ARITH;
            default:                        c = CL_ARITH;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/alu_pg_unit.sv
module alu_pg_unit
    import alu_pg_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NUM_UNITS = 4,
    parameter int UNIT_ID   = 0
) (
    input  logic                en,
    input  logic [OPC_W-1:0]    op,
    input  logic [DATA_W-1:0]   a,
    input  logic [DATA_W-1:0]   b,
    output logic [DATA_W-1:0]   y
);
    localparam int SH_W = $clog2(DATA_W);

    logic [DATA_W-1:0] ia, ib;
    logic [SH_W-1:0]   shamt;
    logic              owns;
    logic [DATA_W-1:0] raw;

    // Operand isolation: a gated unit sees constant inputs.
    assign ia    = en ? a : '0;
    assign ib    = en ? b : '0;
    assign shamt = ib[SH_W-1:0];
    assign owns  = (int'(unit_of(op, NUM_UNITS)) == UNIT_ID);

    always_comb begin
        raw = '0;
        case (op)
            OP_ADD:   raw = ia + ib;
            OP_SUB:   raw = ia - ib;
            OP_AND:   raw = ia & ib;
            OP_OR:    raw = ia | ib;
            OP_XOR:   raw = ia ^ ib;
            OP_SLL:   raw = ia << shamt;
            OP_SRL:   raw = ia >> shamt;
            OP_SRA:   raw = $unsigned($signed(ia) >>> shamt);
            OP_SLT:   raw = {{(DATA_W-1){1'b0}}, $signed(ia) < $signed(ib)};
            OP_SLTU:  raw = {{(DATA_W-1){1'b0}}, ia < ib};
            OP_PASS:  raw = ia;
            OP_CMPEQ: raw = {{(DATA_W-1){1'b0}}, ia == ib};
            default:  raw = '0;
        endcase
    end

    assign y = owns ? raw : '0;

endmodule

// File: rtl/alu_pg_ctrl.sv
module alu_pg_ctrl #(
    parameter int CNT_W       = 10,
    parameter int WAKE_CYCLES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             acc,
    input  logic [CNT_W-1:0] limit,
    output logic             pwr,
    output logic             ready
);
    localparam int WK_W = $clog2(WAKE_CYCLES + 1);
    localparam logic [WK_W-1:0] WK_INIT = WK_W'(WAKE_CYCLES - 1);

    logic [WK_W-1:0]  wake_q;
    logic [CNT_W-1:0] idle_q;
    logic [CNT_W:0]   idle_nx;

    assign idle_nx = {1'b0, idle_q} + 1'b1;
    assign ready   = pwr && (wake_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pwr    <= 1'b0;
            wake_q <= '0;
            idle_q <= '0;
        end else if (!pwr) begin
            if (req) begin
                pwr    <= 1'b1;
                wake_q <= WK_INIT;
                idle_q <= '0;
            end
        end else if (wake_q != '0) begin
            wake_q <= wake_q - 1'b1;
        end else if (acc) begin
            idle_q <= '0;
        end else if (idle_nx >= {1'b0, limit}) begin
            pwr    <= 1'b0;
            idle_q <= '0;
        end else begin
            idle_q <= idle_nx[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/alu_pg_top.sv
module alu_pg_top
    import alu_pg_pkg::*;
#(
    parameter int NUM_UNITS   = 4,
    parameter int DATA_W      = 32,
    parameter int CNT_W       = 10,
    parameter int WAKE_CYCLES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [3:0]           in_op,
    input  logic [DATA_W-1:0]    in_a,
    input  logic [DATA_W-1:0]    in_b,
    input  logic [CNT_W-1:0]     idle_limit,
    output logic                 in_ready,
    output logic                 out_valid,
    output logic [DATA_W-1:0]    out_result,
    output logic [NUM_UNITS-1:0] pwr_en
);
    localparam int SEL_W = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1;

    logic [SEL_W-1:0]     sel;
    logic [NUM_UNITS-1:0] ready_u;
    logic [NUM_UNITS-1:0] req_u;
    logic [NUM_UNITS-1:0] acc_u;
    logic [DATA_W-1:0]    unit_y [NUM_UNITS];
    logic [DATA_W-1:0]    mux_y;
    logic                 accept;

    assign sel = SEL_W'(unit_of(in_op, NUM_UNITS));

    always_comb begin
        in_ready = 1'b0;
        for (int i = 0; i < NUM_UNITS; i++) begin
            if (sel == SEL_W'(i)) in_ready = ready_u[i];
        end
    end

    assign accept = in_valid && in_ready;

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        assign req_u[u] = in_valid && (sel == SEL_W'(u));
        assign acc_u[u] = accept && (sel == SEL_W'(u));

        alu_pg_ctrl #(
            .CNT_W      (CNT_W),
            .WAKE_CYCLES(WAKE_CYCLES)
        ) u_ctrl (
            .clk  (clk),
            .rst  (rst),
            .req  (req_u[u]),
            .acc  (acc_u[u]),
            .limit(idle_limit),
            .pwr  (pwr_en[u]),
            .ready(ready_u[u])
        );

        alu_pg_unit #(
            .DATA_W   (DATA_W),
            .NUM_UNITS(NUM_UNITS),
            .UNIT_ID  (u)
        ) u_alu (
            .en(pwr_en[u]),
            .op(in_op),
            .a (in_a),
            .b (in_b),
            .y (unit_y[u])
        );
    end

    always_comb begin
        mux_y = '0;
        for (int i = 0; i < NUM_UNITS; i++) begin
            if (sel == SEL_W'(i)) mux_y = unit_y[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= accept;
            if (accept) out_result <= mux_y;
        end
    end

endmodule

// File: rtl/alu_pg_chk.sv
module alu_pg_chk
    import alu_pg_pkg::*;
#(
    parameter int NUM_UNITS = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic [3:0]           in_op,
    input logic                 in_ready,
    input logic                 out_valid,
    input logic [NUM_UNITS-1:0] pwr_en
);
    int unsigned cl;
    logic        acc;

    assign cl  = int'(unit_of(in_op, NUM_UNITS));
    assign acc = in_valid && in_ready;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (pwr_en == '0 && !out_valid)); // R4

    AST_VALID_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        acc |=> out_valid); // R3

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !acc |=> !out_valid); // R3

    AST_ISSUE_POWERED: assert property (@(posedge clk) disable iff (rst)
        acc |-> pwr_en[cl]); // R1

    AST_GATED_STALLS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !pwr_en[cl]) |-> !in_ready); // R5

    AST_WAKE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !pwr_en[cl]) |=> pwr_en[$past(cl)]); // R5

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_u
        AST_WAKE_ON_DEMAND: assert property (@(posedge clk) disable iff (rst)
            $rose(pwr_en[u]) |-> $past(in_valid && cl == u)); // R5

        AST_NO_GATE_ON_USE: assert property (@(posedge clk) disable iff (rst)
            $fell(pwr_en[u]) |-> !$past(acc && cl == u)); // R7
    end

endmodule

bind alu_pg_top alu_pg_chk #(.NUM_UNITS(NUM_UNITS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_op    (in_op),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .pwr_en   (pwr_en)
);

// File: tb/sim_alu_pg_top.sv
module sim_alu_pg_top;
    localparam int W = 32;
    localparam int WAKE = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        v0 = 1'b0, v1 = 1'b0;
    logic [3:0]  op = '0;
    logic [W-1:0] a = '0, b = '0;
    logic [9:0]  lim = 10'd1000;
    logic        rdy0, rdy1, ov0, ov1;
    logic [W-1:0] res0, res1;
    logic [3:0]  pe0;
    logic [2:0]  pe1;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    alu_pg_top #(.NUM_UNITS(4)) u0 (
        .clk(clk), .rst(rst), .in_valid(v0), .in_op(op), .in_a(a), .in_b(b),
        .idle_limit(lim), .in_ready(rdy0), .out_valid(ov0), .out_result(res0),
        .pwr_en(pe0));

    alu_pg_top #(.NUM_UNITS(3)) u1 (
        .clk(clk), .rst(rst), .in_valid(v1), .in_op(op), .in_a(a), .in_b(b),
        .idle_limit(lim), .in_ready(rdy1), .out_valid(ov1), .out_result(res1),
        .pwr_en(pe1));

    function automatic int ref_unit(logic [3:0] o, int n);
        if (o inside {4'd2, 4'd3, 4'd4, 4'd10}) return 1;
        if (o inside {4'd5, 4'd6, 4'd7}) return 2;
        if (o inside {4'd8, 4'd9, 4'd11}) return (n == 4) ? 3 : 0;
        return 0;
    endfunction

    function automatic logic [W-1:0] ref_alu(logic [3:0] o, logic [W-1:0] x, logic [W-1:0] y);
        case (o)
            4'd0:  return x + y;
            4'd1:  return x - y;
            4'd2:  return x & y;
            4'd3:  return x | y;
            4'd4:  return x ^ y;
            4'd5:  return x << y[4:0];
            4'd6:  return x >> y[4:0];
            4'd7:  return $unsigned($signed(x) >>> y[4:0]);
            4'd8:  return ($signed(x) < $signed(y)) ? 1 : 0;
            4'd9:  return (x < y) ? 1 : 0;
            4'd10: return x;
            4'd11: return (x == y) ? 1 : 0;
            default: return '0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; v0 = 1'b0; v1 = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // Caller is at a falling edge. Returns at the falling edge after acceptance.
    task automatic do_op(input bit which, input logic [3:0] o, input logic [W-1:0] x,
                         input logic [W-1:0] y, input int exp_stall, input string req);
        int stalls = 0;
        op = o; a = x; b = y;
        if (which) v1 = 1'b1; else v0 = 1'b1;
        #1;
        while (!(which ? rdy1 : rdy0) && stalls < 50) begin
            stalls++;
            @(negedge clk); #1;
        end
        @(negedge clk);
        v0 = 1'b0; v1 = 1'b0;
        chk(stalls == exp_stall, "R5 stall count", stalls, exp_stall);
        chk((which ? ov1 : ov0) == 1'b1, "R3 out_valid", which ? ov1 : ov0, 1);
        chk((which ? res1 : res0) == ref_alu(o, x, y), {req, " result"},
            which ? res1 : res0, ref_alu(o, x, y));
    endtask

    task automatic t_reset();
        do_reset();
        chk(pe0 == 4'b0000, "R4 pwr_en after reset", pe0, 0);
        chk(ov0 == 1'b0, "R4 out_valid after reset", ov0, 0);
        chk(pe1 == 3'b000, "R4 pwr_en 3-unit after reset", pe1, 0);
    endtask

    task automatic t_all_ops();
        logic [W-1:0] pa [4] = '{32'd5, 32'hFFFF_FFFF, 32'h8000_0000, 32'h1234_5678};
        logic [W-1:0] pb [4] = '{32'd3, 32'd1, 32'd31, 32'h1234_5678};
        logic [3:0] mask = '0;
        do_reset();
        lim = 10'd1000;
        for (int p = 0; p < 4; p++) begin
            for (int o = 0; o < 16; o++) begin
                int u = ref_unit(4'(o), 4);
                do_op(1'b0, 4'(o), pa[p], pb[p], mask[u] ? 0 : WAKE, "R2");
                mask[u] = 1'b1;
                chk(pe0 == mask, "R1 only used units powered", pe0, mask);
                @(negedge clk);
                chk(ov0 == 1'b0, "R3 out_valid drops", ov0, 0);
            end
        end
    endtask

    task automatic t_timeout(input int L);
        do_reset();
        lim = 10'(L);
        do_op(1'b0, 4'd5, 32'd1, 32'd4, WAKE, "R6");
        repeat (L - 1) @(negedge clk);
        chk(pe0[2] == 1'b1, "R6 still powered at t+L", pe0[2], 1);
        @(negedge clk);
        chk(pe0[2] == 1'b0, "R6 gated at t+L+1", pe0[2], 0);
    endtask

    task automatic t_race();
        do_reset();
        lim = 10'd10;
        do_op(1'b0, 4'd8, 32'd1, 32'd2, WAKE, "R7");
        repeat (9) @(negedge clk);
        chk(pe0[3] == 1'b1, "R7 last powered cycle", pe0[3], 1);
        do_op(1'b0, 4'd11, 32'd7, 32'd7, 0, "R7");
        repeat (9) @(negedge clk);
        chk(pe0[3] == 1'b1, "R7 window restarted", pe0[3], 1);
        @(negedge clk);
        chk(pe0[3] == 1'b0, "R7 gated after new window", pe0[3], 0);
    endtask

    task automatic t_indep();
        do_reset();
        lim = 10'd10;
        do_op(1'b0, 4'd0, 32'd2, 32'd3, WAKE, "R8");
        repeat (3) @(negedge clk);
        do_op(1'b0, 4'd4, 32'hF0, 32'h0F, WAKE, "R8");
        // unit 0 accepted at t; now at falling edge of cycle t+7
        repeat (3) @(negedge clk);
        chk(pe0[0] == 1'b1, "R8 unit0 powered at t+10", pe0[0], 1);
        @(negedge clk);
        chk(pe0[0] == 1'b0, "R8 unit0 gated at t+11", pe0[0], 0);
        chk(pe0[1] == 1'b1, "R8 unit1 still powered", pe0[1], 1);
    endtask

    task automatic t_three();
        do_reset();
        lim = 10'd1000;
        do_op(1'b1, 4'd0, 32'd9, 32'd4, WAKE, "R9");
        do_op(1'b1, 4'd8, 32'hFFFF_FFFF, 32'd0, 0, "R9");
        do_op(1'b1, 4'd11, 32'd3, 32'd3, 0, "R9");
        chk(pe1 == 3'b001, "R9 compare shares arith unit", pe1, 1);
        do_op(1'b0, 4'd0, 32'd9, 32'd4, WAKE, "R9 4-unit");
        do_op(1'b0, 4'd8, 32'd1, 32'd0, WAKE, "R9 4-unit separate compare");
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_all_ops();
        t_timeout(10);
        t_timeout(20);
        t_timeout(50);
        t_timeout(100);
        t_timeout(500);
        t_race();
        t_indep();
        t_three();
        finish_run();
    end

endmodule